// File: doc/BRIEF.md
# Packed Single-Precision Range Selector

This block processes four lanes of IEEE-754 single-precision values per request. In each lane it picks one of two operands with a chosen ordering rule: smallest, largest, smallest magnitude or largest magnitude. It then rewrites the sign bit of the picked value according to a separate sign policy. The ordering rule and the sign policy are set independently, so one request can, for example, clamp a value to a symmetric bound while keeping the value's own sign.

A per-lane enable mask controls which lanes are computed. A disabled lane either keeps the supplied old destination lane or is cleared to zero. A broadcast option feeds lane 0 of the second vector to every lane. A flush option treats subnormal inputs as signed zeros. NaN inputs, zeros of opposite sign, and equal magnitudes of opposite sign follow fixed precedence rules. An invalid flag and a subnormal flag are collected over the computed lanes.

The lane logic is purely combinational. The result and the flags are captured in a register on the clock edge after an accepted request. `out_valid` pulses in the following cycle.

Top module: `fp_range_select`

## Requirements
- R1: `ctrl[1:0]` picks the ordering rule: 0 smaller value, 1 larger value, 2 smaller magnitude, 3 larger magnitude. A tie under "less or equal" goes to operand A in modes 0 and 2, and to operand B in modes 1 and 3. Magnitude compares bits [30:0]. A negative value orders below any positive value.
- R2: `ctrl[3:2]` picks the output sign: 0 sign of operand A, 1 sign of the picked value, 2 cleared, 3 set. Bits [30:0] always come from the picked value.
- R3: A request with `ctrl[7:4]` nonzero produces no result. In the next cycle `ctrl_illegal` is 1, `out_valid` is 0, and the result and flags keep their previous values.
- R4: A signalling NaN has exponent 0xFF, a nonzero fraction and fraction bit 22 clear. If A is one, the lane returns A with bit 22 set. Otherwise, if B is one, the lane returns B with bit 22 set. In both cases the invalid flag is raised and the sign policy is skipped.
- R5: A quiet NaN has exponent 0xFF and fraction bit 22 set. If B is a quiet NaN, the picked value is A. Otherwise, if A is a quiet NaN, the picked value is B. The sign policy still applies.
- R6: A subnormal has exponent 0 and a nonzero fraction. When `daz` is 1, its fraction is treated as 0, both for ordering and in the returned value. When `daz` is 0, it raises the subnormal flag, unless the other operand is a quiet NaN or either operand is a signalling NaN.
- R7: A lane is computed when `mask_en` is 0 or its `lane_mask` bit is 1. Otherwise the lane takes `dest_old` when `zero_mode` is 0, and 0 when `zero_mode` is 1.
- R8: When `bcast` is 1, bits [31:0] of `src_b` are operand B for every lane.
- R9: For zeros of opposite sign (after flushing), mode 0 gives -0 (0x80000000), mode 1 gives +0, mode 2 gives A and mode 3 gives B. The sign policy then applies.
- R10: For nonzero equal magnitudes of opposite sign, mode 2 picks the negative operand and mode 3 picks the positive one.
- R11: `flag_invalid` and `flag_denorm` are the OR over computed lanes only. Disabled lanes never contribute.
- R12: An accepted request (`in_valid` with legal control) makes `out_valid` 1 in the next cycle, with the new result. With no request, `out_valid` is 0 and the result holds. Lane j occupies bits [32j+31:32j].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request strobe |
| src_a | input | 128 | Operand A vector, four lanes |
| src_b | input | 128 | Operand B vector, four lanes |
| ctrl | input | 8 | [1:0] ordering rule, [3:2] sign policy, [7:4] must be zero |
| lane_mask | input | 4 | Per-lane enable |
| mask_en | input | 1 | Apply lane_mask |
| zero_mode | input | 1 | Disabled lanes become zero instead of old value |
| bcast | input | 1 | Use lane 0 of src_b for all lanes |
| daz | input | 1 | Treat subnormal inputs as zero |
| dest_old | input | 128 | Previous destination contents |
| out_valid | output | 1 | Result valid pulse |
| result | output | 128 | Registered result vector |
| flag_invalid | output | 1 | Signalling NaN seen in a computed lane |
| flag_denorm | output | 1 | Subnormal seen in a computed lane |
| ctrl_illegal | output | 1 | Last request had nonzero upper control bits |

## Verification
Masking and flag gathering can act in the same request. A lane holding a signalling NaN or a subnormal may be disabled, while a neighbouring computed lane holds ordinary values, or a flag source of its own. The random stimulus mixes special-value operands with random masks, merge or zero mode and broadcast. Each request is judged against a bench model that ORs flags only over enabled lanes and fills disabled lanes from the old destination or zero.

// File: rtl/fprs_pkg.sv
package fprs_pkg;
    localparam int unsigned ELEM_W  = 32;
    localparam int unsigned EXP_MSB = 30;
    localparam int unsigned EXP_LSB = 23;
    localparam int unsigned QBIT    = 22;

    typedef enum logic [1:0] {
        ORD_MIN    = 2'b00,
        ORD_MAX    = 2'b01,
        ORD_MINMAG = 2'b10,
        ORD_MAXMAG = 2'b11
    } ord_e;

    typedef enum logic [1:0] {
        SGN_FROM_A = 2'b00,
        SGN_KEEP   = 2'b01,
        SGN_CLEAR  = 2'b10,
        SGN_SET    = 2'b11
    } sgn_e;
endpackage

// File: rtl/fprs_classify.sv
module fprs_classify
    import fprs_pkg::*;
(
    input  logic [ELEM_W-1:0] x,
    input  logic              daz,
    output logic [ELEM_W-1:0] x_eff,
    output logic              is_snan,
    output logic              is_qnan,
    output logic              is_sub,
    output logic              is_zero
);
    logic exp_ones;
    logic exp_zero;
    logic frac_nz;

    always_comb begin
        exp_ones = &x[EXP_MSB:EXP_LSB];
        exp_zero = ~|x[EXP_MSB:EXP_LSB];
        frac_nz  = |x[QBIT:0];
        is_snan  = exp_ones & frac_nz & ~x[QBIT];
        is_qnan  = exp_ones & x[QBIT];
        is_sub   = exp_zero & frac_nz;
        x_eff    = (is_sub && daz) ? {x[ELEM_W-1], {(ELEM_W-1){1'b0}}} : x;
        is_zero  = ~|x_eff[ELEM_W-2:0];
    end
endmodule

// File: rtl/fprs_order.sv
module fprs_order
    import fprs_pkg::*;
(
    input  logic [ELEM_W-1:0] a,
    input  logic [ELEM_W-1:0] b,
    output logic              le_val,
    output logic              le_mag,
    output logic              mag_eq
);
    logic [ELEM_W-2:0] ma;
    logic [ELEM_W-2:0] mb;

    always_comb begin
        ma     = a[ELEM_W-2:0];
        mb     = b[ELEM_W-2:0];
        le_mag = (ma <= mb);
        mag_eq = (ma == mb);
        if (a[ELEM_W-1] != b[ELEM_W-1]) begin
            le_val = a[ELEM_W-1];
        end else if (a[ELEM_W-1]) begin
            le_val = (ma >= mb);
        end else begin
            le_val = (ma <= mb);
        end
    end
endmodule

// File: rtl/fprs_lane.sv
module fprs_lane
    import fprs_pkg::*;
(
    input  logic [ELEM_W-1:0] op_a,
    input  logic [ELEM_W-1:0] op_b,
    input  logic [3:0]        mode,
    input  logic              daz,
    output logic [ELEM_W-1:0] lane_out,
    output logic              lane_inv,
    output logic              lane_sub
);
    logic [ELEM_W-1:0] a_eff;
    logic [ELEM_W-1:0] b_eff;
    logic a_snan, a_qnan, a_sub, a_zero;
    logic b_snan, b_qnan, b_sub, b_zero;
    logic le_val, le_mag, mag_eq;
    logic [ELEM_W-1:0] pick;
    logic              pick_sgn;
    ord_e              ord;
    sgn_e              sgn;

    fprs_classify u_cls_a (
        .x(op_a), .daz(daz), .x_eff(a_eff),
        .is_snan(a_snan), .is_qnan(a_qnan), .is_sub(a_sub), .is_zero(a_zero)
    );

    fprs_classify u_cls_b (
        .x(op_b), .daz(daz), .x_eff(b_eff),
        .is_snan(b_snan), .is_qnan(b_qnan), .is_sub(b_sub), .is_zero(b_zero)
    );

    fprs_order u_ord (
        .a(a_eff), .b(b_eff),
        .le_val(le_val), .le_mag(le_mag), .mag_eq(mag_eq)
    );

    always_comb begin
        ord      = ord_e'(mode[1:0]);
        sgn      = sgn_e'(mode[3:2]);
        lane_inv = a_snan | b_snan;
        lane_sub = ~lane_inv & ~daz &
                   ((a_sub & ~b_qnan) | (b_sub & ~a_qnan));

        if (b_qnan) begin
            pick = a_eff;
        end else if (a_qnan) begin
            pick = b_eff;
        end else if (a_zero && b_zero && (a_eff[ELEM_W-1] != b_eff[ELEM_W-1])) begin
            unique case (ord)
                ORD_MIN:    pick = {1'b1, {(ELEM_W-1){1'b0}}};
                ORD_MAX:    pick = '0;
                ORD_MINMAG: pick = a_eff;
                default:    pick = b_eff;
            endcase
        end else if (mode[1] && mag_eq && (a_eff[ELEM_W-1] != b_eff[ELEM_W-1])) begin
            if (ord == ORD_MINMAG) begin
                pick = a_eff[ELEM_W-1] ? a_eff : b_eff;
            end else begin
                pick = a_eff[ELEM_W-1] ? b_eff : a_eff;
            end
        end else begin
            unique case (ord)
                ORD_MIN:    pick = le_val ? a_eff : b_eff;
                ORD_MAX:    pick = le_val ? b_eff : a_eff;
                ORD_MINMAG: pick = le_mag ? a_eff : b_eff;
                default:    pick = le_mag ? b_eff : a_eff;
            endcase
        end

        unique case (sgn)
            SGN_FROM_A: pick_sgn = op_a[ELEM_W-1];
            SGN_KEEP:   pick_sgn = pick[ELEM_W-1];
            SGN_CLEAR:  pick_sgn = 1'b0;
            default:    pick_sgn = 1'b1;
        endcase

        if (a_snan) begin
            lane_out = op_a | (ELEM_W'(1) << QBIT);
        end else if (b_snan) begin
            lane_out = op_b | (ELEM_W'(1) << QBIT);
        end else begin
            lane_out = {pick_sgn, pick[ELEM_W-2:0]};
        end
    end
endmodule

// File: rtl/fp_range_select.sv
module fp_range_select
    import fprs_pkg::*;
#(
    parameter int unsigned LANES = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [LANES*ELEM_W-1:0]   src_a,
    input  logic [LANES*ELEM_W-1:0]   src_b,
    input  logic [7:0]                ctrl,
    input  logic [LANES-1:0]          lane_mask,
    input  logic                      mask_en,
    input  logic                      zero_mode,
    input  logic                      bcast,
    input  logic                      daz,
    input  logic [LANES*ELEM_W-1:0]   dest_old,
    output logic                      out_valid,
    output logic [LANES*ELEM_W-1:0]   result,
    output logic                      flag_invalid,
    output logic                      flag_denorm,
    output logic                      ctrl_illegal
);
    localparam int unsigned VEC_W = LANES * ELEM_W;

    typedef struct packed {
        logic [VEC_W-1:0] res;
        logic             inv;
        logic             sub;
        logic             vld;
        logic             ill;
    } state_t;

    state_t st_d;
    state_t st_q;

    logic [VEC_W-1:0] lane_vec;
    logic [LANES-1:0] inv_vec;
    logic [LANES-1:0] sub_vec;
    logic             ctrl_bad;

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [ELEM_W-1:0] b_in;
        logic [ELEM_W-1:0] l_out;
        logic              l_inv;
        logic              l_sub;
        logic              l_en;

        assign b_in = bcast ? src_b[ELEM_W-1:0] : src_b[j*ELEM_W +: ELEM_W];
        assign l_en = ~mask_en | lane_mask[j];

        fprs_lane u_lane (
            .op_a(src_a[j*ELEM_W +: ELEM_W]),
            .op_b(b_in),
            .mode(ctrl[3:0]),
            .daz(daz),
            .lane_out(l_out),
            .lane_inv(l_inv),
            .lane_sub(l_sub)
        );

        assign lane_vec[j*ELEM_W +: ELEM_W] = l_en ? l_out :
                                              (zero_mode ? '0 : dest_old[j*ELEM_W +: ELEM_W]);
        assign inv_vec[j] = l_en & l_inv;
        assign sub_vec[j] = l_en & l_sub;
    end

    assign ctrl_bad = |ctrl[7:4];

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        st_d.ill = 1'b0;
        if (in_valid) begin
            if (ctrl_bad) begin
                st_d.ill = 1'b1;
            end else begin
                st_d.vld = 1'b1;
                st_d.res = lane_vec;
                st_d.inv = |inv_vec;
                st_d.sub = |sub_vec;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid    = st_q.vld;
    assign result       = st_q.res;
    assign flag_invalid = st_q.inv;
    assign flag_denorm  = st_q.sub;
    assign ctrl_illegal = st_q.ill;
endmodule

// File: rtl/fprs_checker.sv
module fprs_checker (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [127:0] src_a,
    input logic [127:0] src_b,
    input logic [7:0]   ctrl,
    input logic [3:0]   lane_mask,
    input logic         mask_en,
    input logic         zero_mode,
    input logic         out_valid,
    input logic [127:0] result,
    input logic         flag_invalid,
    input logic         flag_denorm,
    input logic         ctrl_illegal
);
    logic legal_req;
    logic a0_snan;
    logic b0_snan;

    assign legal_req = in_valid && (ctrl[7:4] == 4'd0);
    assign a0_snan   = (src_a[30:23] == 8'hFF) && (src_a[22:0] != 0) && !src_a[22];
    assign b0_snan   = (src_b[30:23] == 8'hFF) && (src_b[22:0] != 0) && !src_b[22];

    assert_accept_R12: assert property (@(posedge clk) disable iff (!rst_n)
        legal_req |=> (out_valid && !ctrl_illegal));

    assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result)));

    assert_illegal_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ctrl[7:4] != 4'd0) |=> (ctrl_illegal && !out_valid && $stable(result)
                                             && $stable(flag_invalid) && $stable(flag_denorm)));

    assert_zero_lane_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (legal_req && mask_en && zero_mode && !lane_mask[0]) |=> (result[31:0] == 32'd0));

    assert_force_sign_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (legal_req && ctrl[3:2] == 2'b11 && !mask_en && !a0_snan && !b0_snan) |=> result[31]);

    assert_no_flags_masked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (legal_req && mask_en && lane_mask == 4'd0) |=> (!flag_invalid && !flag_denorm));
endmodule

bind fp_range_select fprs_checker i_fprs_checker (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_a(src_a), .src_b(src_b),
    .ctrl(ctrl), .lane_mask(lane_mask), .mask_en(mask_en), .zero_mode(zero_mode),
    .out_valid(out_valid), .result(result), .flag_invalid(flag_invalid),
    .flag_denorm(flag_denorm), .ctrl_illegal(ctrl_illegal)
);

// File: tb/test_fp_range_select.sv
module test_fp_range_select;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] src_a = '0;
    logic [127:0] src_b = '0;
    logic [7:0]   ctrl = '0;
    logic [3:0]   lane_mask = '0;
    logic         mask_en = 1'b0;
    logic         zero_mode = 1'b0;
    logic         bcast = 1'b0;
    logic         daz = 1'b0;
    logic [127:0] dest_old = '0;
    logic         out_valid;
    logic [127:0] result;
    logic         flag_invalid;
    logic         flag_denorm;
    logic         ctrl_illegal;

    int n_chk = 0;
    int n_bad = 0;

    logic [127:0] exp_res = '0;
    logic         exp_inv = 1'b0;
    logic         exp_sub = 1'b0;

    always #10 clk = ~clk;

    fp_range_select i_fp_range_select (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_a(src_a), .src_b(src_b),
        .ctrl(ctrl), .lane_mask(lane_mask), .mask_en(mask_en), .zero_mode(zero_mode),
        .bcast(bcast), .daz(daz), .dest_old(dest_old), .out_valid(out_valid),
        .result(result), .flag_invalid(flag_invalid), .flag_denorm(flag_denorm),
        .ctrl_illegal(ctrl_illegal)
    );

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic logic [31:0] okey(input logic [31:0] x);
        return x[31] ? {1'b0, ~x[30:0]} : {1'b1, x[30:0]};
    endfunction

    function automatic logic [31:0] ref_lane(input logic [31:0] a, input logic [31:0] b,
                                             input logic [3:0] c, input logic dz,
                                             output logic inv, output logic sub);
        logic anan, bnan, asn, bsn, aqn, bqn;
        logic [31:0] fa, fb, t;
        logic s;
        anan = (a[30:23] == 8'hFF) && (a[22:0] != 0);
        bnan = (b[30:23] == 8'hFF) && (b[22:0] != 0);
        asn = anan && !a[22];  aqn = anan && a[22];
        bsn = bnan && !b[22];  bqn = bnan && b[22];
        inv = 1'b0; sub = 1'b0;
        if (asn) begin inv = 1'b1; return a | 32'h0040_0000; end
        if (bsn) begin inv = 1'b1; return b | 32'h0040_0000; end
        fa = (dz && a[30:23] == 0) ? {a[31], 31'd0} : a;
        fb = (dz && b[30:23] == 0) ? {b[31], 31'd0} : b;
        if (!dz && a[30:23] == 0 && a[22:0] != 0 && !bqn) sub = 1'b1;
        if (!dz && b[30:23] == 0 && b[22:0] != 0 && !aqn) sub = 1'b1;
        if (bqn) t = fa;
        else if (aqn) t = fb;
        else if (fa[30:0] == 0 && fb[30:0] == 0 && fa[31] != fb[31]) begin
            case (c[1:0])
                2'd0: t = 32'h8000_0000;
                2'd1: t = 32'h0;
                2'd2: t = fa;
                default: t = fb;
            endcase
        end else if (c[1] && fa[30:0] == fb[30:0] && fa[31] != fb[31]) begin
            if (c[0]) t = fa[31] ? fb : fa;
            else      t = fa[31] ? fa : fb;
        end else begin
            case (c[1:0])
                2'd0: t = (okey(fa) <= okey(fb)) ? fa : fb;
                2'd1: t = (okey(fa) <= okey(fb)) ? fb : fa;
                2'd2: t = (fa[30:0] <= fb[30:0]) ? fa : fb;
                default: t = (fa[30:0] <= fb[30:0]) ? fb : fa;
            endcase
        end
        case (c[3:2])
            2'd0: s = a[31];
            2'd1: s = t[31];
            2'd2: s = 1'b0;
            default: s = 1'b1;
        endcase
        return {s, t[30:0]};
    endfunction

    task automatic predict();
        logic iv, sv;
        logic [31:0] bb;
        if (ctrl[7:4] != 0) return;
        exp_inv = 1'b0; exp_sub = 1'b0;
        for (int j = 0; j < 4; j++) begin
            bb = bcast ? src_b[31:0] : src_b[j*32 +: 32];
            if (!mask_en || lane_mask[j]) begin
                exp_res[j*32 +: 32] = ref_lane(src_a[j*32 +: 32], bb, ctrl[3:0], daz, iv, sv);
                exp_inv |= iv;
                exp_sub |= sv;
            end else begin
                exp_res[j*32 +: 32] = zero_mode ? 32'd0 : dest_old[j*32 +: 32];
            end
        end
    endtask

    task automatic issue(input string req);
        logic legal;
        legal = (ctrl[7:4] == 0);
        predict();
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk({req, " result"}, result, exp_res);
        chk({req, " flags"}, {126'd0, flag_invalid, flag_denorm}, {126'd0, exp_inv, exp_sub});
        chk({req, " valid/illegal"}, {126'd0, out_valid, ctrl_illegal}, {126'd0, legal, !legal});
    endtask

    task automatic plain();
        mask_en = 0; zero_mode = 0; bcast = 0; daz = 0; lane_mask = 4'hF;
    endtask

    function automatic logic [31:0] rnd_val();
        logic [31:0] r;
        r = $urandom;
        case ($urandom % 10)
            0: return r;
            1: return {r[31], 31'd0};
            2: return {r[31], 8'd0, r[22:1], 1'b1};
            3: return {r[31], 8'hFF, 1'b1, r[21:0]};
            4: return {r[31], 8'hFF, 1'b0, r[21:1], 1'b1};
            5: return {r[31], 8'hFF, 23'd0};
            default: return {r[31], 6'b100000, r[1:0], r[22:20], 20'd0};
        endcase
    endfunction

    initial begin
        #3_000_000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk("reset R12", {result, 4'd0}, '0);
        chk("reset R12 status", {124'd0, out_valid, flag_invalid, flag_denorm, ctrl_illegal}, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: ordering modes with ties and mixed signs
        plain();
        src_a = {32'h3F80_0000, 32'hBF80_0000, 32'h4000_0000, 32'hC040_0000};
        src_b = {32'h4000_0000, 32'h3F80_0000, 32'h4000_0000, 32'h4000_0000};
        for (int m = 0; m < 4; m++) begin
            ctrl = {4'd0, 2'b01, m[1:0]};
            issue("R1");
        end
        // literal: min of 1.0 and 2.0 with own sign
        ctrl = 8'h04; src_a[31:0] = 32'h3F80_0000; src_b[31:0] = 32'h4000_0000;
        issue("R1");
        chk("R1 literal min", {96'd0, result[31:0]}, {96'd0, 32'h3F80_0000});

        // R2: clamp -200 to magnitude 150, sign from A -> -150
        src_a[31:0] = 32'hC348_0000; src_b[31:0] = 32'h4316_0000; ctrl = 8'h02;
        issue("R2");
        chk("R2 literal clamp", {96'd0, result[31:0]}, {96'd0, 32'hC316_0000});
        for (int s = 0; s < 4; s++) begin
            ctrl = {4'd0, s[1:0], 2'b01};
            issue("R2");
        end

        // R3: illegal control keeps result
        ctrl = 8'h15; src_a = '1; issue("R3");
        chk("R3 hold", result, exp_res);

        // R4: signalling NaNs in both, A first
        src_a = {32'h7F80_0001, 32'h3F80_0000, 32'hFF80_0010, 32'h0};
        src_b = {32'h7F80_0002, 32'h7FA0_0000, 32'h3F80_0000, 32'h0};
        ctrl = 8'h0C; issue("R4");
        chk("R4 literal lane3", {96'd0, result[127:96]}, {96'd0, 32'h7FC0_0001});

        // R5: quiet NaN passthrough with sign policy
        src_a = {32'h7FC0_0000, 32'hC000_0000, 32'h7FC0_0000, 32'h4000_0000};
        src_b = {32'hBF80_0000, 32'hFFC0_0000, 32'h7FC0_0000, 32'h7FD0_0000};
        ctrl = 8'h09; issue("R5");

        // R6: subnormals with and without flush
        src_a = {32'h0000_0001, 32'h8000_0010, 32'h0040_0000, 32'h3F80_0000};
        src_b = {32'h0000_0002, 32'h0000_0000, 32'h7FC0_0000, 32'h0000_0005};
        ctrl = 8'h04; daz = 0; issue("R6");
        daz = 1; issue("R6");
        chk("R6 flush lane2", {96'd0, result[95:64]}, {96'd0, 32'h8000_0000});
        daz = 0;

        // R9: opposite zeros, all modes
        src_a = {4{32'h0000_0000}}; src_b = {4{32'h8000_0000}};
        for (int m = 0; m < 4; m++) begin ctrl = {4'd0, 2'b01, m[1:0]}; issue("R9"); end
        chk("R9 maxmag", {96'd0, result[31:0]}, {96'd0, 32'h8000_0000});

        // R10: equal magnitude, opposite sign
        src_a = {4{32'h4120_0000}}; src_b = {4{32'hC120_0000}};
        ctrl = 8'h06; issue("R10");
        chk("R10 minmag neg", {96'd0, result[31:0]}, {96'd0, 32'hC120_0000});
        ctrl = 8'h07; issue("R10");

        // R7/R8/R11: masking, broadcast, flags from enabled lanes only
        src_a = {32'h7F80_0001, 32'h0000_0003, 32'h3F80_0000, 32'h4000_0000};
        src_b = {32'h3F80_0000, 32'h3F80_0000, 32'h4040_0000, 32'hC000_0000};
        dest_old = {32'hAAAA_AAAA, 32'hBBBB_BBBB, 32'hCCCC_CCCC, 32'hDDDD_DDDD};
        mask_en = 1; lane_mask = 4'b0011; ctrl = 8'h04;
        zero_mode = 0; issue("R7 merge R11");
        zero_mode = 1; issue("R7 zero R11");
        bcast = 1; lane_mask = 4'b1111; zero_mode = 0; issue("R8 R11");
        plain();

        // random mix
        for (int k = 0; k < 400; k++) begin
            for (int j = 0; j < 4; j++) begin
                src_a[j*32 +: 32] = rnd_val();
                case ($urandom % 4)
                    0: src_b[j*32 +: 32] = src_a[j*32 +: 32] ^ 32'h8000_0000;
                    1: src_b[j*32 +: 32] = src_a[j*32 +: 32];
                    default: src_b[j*32 +: 32] = rnd_val();
                endcase
            end
            dest_old  = {$urandom, $urandom, $urandom, $urandom};
            ctrl      = ($urandom % 20 == 0) ? 8'($urandom) : {4'd0, 4'($urandom)};
            mask_en   = 1'($urandom);
            lane_mask = 4'($urandom);
            zero_mode = 1'($urandom);
            bcast     = ($urandom % 4 == 0);
            daz       = 1'($urandom);
            issue("R1 R2 R4 R5 R6 R7 R8 R11 random");
            if ($urandom % 3 == 0) begin
                @(negedge clk);
                chk("R12 idle", {127'd0, out_valid}, 128'd0);
                chk("R12 idle hold", result, exp_res);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule